// File: doc/BRIEF.md
# Serial Boot Mode Stream Loader

This block reads a fixed-length serial configuration word once power becomes good and turns it into static mode outputs for the rest of the chip. It produces its own slow mode clock by dividing the system clock. A cheap serial memory or a companion controller shifts one mode bit per mode clock period into the serial data input. Bit 0 comes first.

When the last bit has arrived, every decoded field loads at the same system clock edge and the done flag rises. Reserved positions and an out-of-range data-rate code raise a sticky configuration-error flag. The effective byte order is the OR of the stream's endian bit and an external strap pin. Dropping power-good returns the whole block to its idle state, and the next power-up loads the stream again from bit 0.

Top module: `boot_mode_loader`

## Requirements
- R1: `mode_clk` is the system clock divided by 256. Counting from the first system edge that sees `pwr_ok` high, it is low for 128 system cycles and then high for 128 cycles, and it repeats this without end. It is low while `pwr_ok` is low.
- R2: One serial bit is sampled at the system edge where `mode_clk` goes high. The first sample after power-up is frame bit 0 and the 256th is frame bit 255.
- R3: `done` and all decoded outputs are zero until the 256th bit is captured. On that edge `done` goes to 1 and all fields load together. After that no further bits are taken and the fields stay fixed.
- R4: The fields and their frame bit positions are: `wb_rate` = bits 4:1 (code 0 to 8 valid), `mult_code` = bits 7:5, `mult_half` = bit 20 (1 = half-integer multiply), `nbw_ctrl` = bits 10:9, `l2_en` = bit 12, `sram_scd` = bit 15, `cfg_id` = bits 17:16, `bus32` = bit 21 (1 = 32-bit bus, 0 = 64-bit bus).
- R5: `timer_int_en` is the inverse of frame bit 11. A 0 in bit 11 enables the timer interrupt.
- R6: `drive_pct` gives the output driver strength in percent, decoded from bits 14:13: 00 gives 67, 01 gives 50, 10 gives 100 and 11 gives 83.
- R7: `big_endian` is a registered OR of frame bit 8 (counted as 0 before `done`) and the `be_pin` input. It follows a change on the pin one system cycle later.
- R8: `cfg_err` is set at the capture edge if any reserved bit is 1 (bit 0, bits 19:18, bits 255:22) or if `wb_rate` is 9 to 15. A rate code of 8 raises no error. Once set, `cfg_err` stays set while `pwr_ok` remains high.
- R9: A system edge with `pwr_ok` low clears the divider, the bit counter, `done`, every decoded output and `cfg_err`. A load cut short this way starts again from bit 0 at the next power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_ok | input | 1 | Power good; low acts as synchronous reset |
| mode_din | input | 1 | Serial mode data |
| be_pin | input | 1 | External big-endian strap |
| mode_clk | output | 1 | Divided mode clock |
| done | output | 1 | Stream fully captured |
| wb_rate | output | 4 | Writeback data-rate code |
| mult_code | output | 3 | Clock multiplier code |
| mult_half | output | 1 | Half-integer multiply select |
| big_endian | output | 1 | Effective byte order |
| nbw_ctrl | output | 2 | Non-block write control |
| timer_int_en | output | 1 | Timer interrupt enable |
| l2_en | output | 1 | Secondary cache enable |
| sram_scd | output | 1 | Single-cycle deselect SRAM type |
| drive_pct | output | 7 | Driver strength percent |
| cfg_id | output | 2 | Configuration identifier |
| bus32 | output | 1 | 32-bit bus select |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
A divider off by one count moves `mode_clk` within the first 128 cycles after power-up. Because the sample point is tied to that clock, the same fault also shifts every captured bit by one position, and that shows as wrong field values at `done`.

A bit counter that is wrong, or that survives an aborted load, shows as `done` rising on the wrong mode clock edge. It also leaves misaligned fields, which cannot be seen until the end of the load, about 65,000 cycles later.

Faults in the decoder and the error logic only appear at the capture edge or afterwards. A misread endian pin appears one cycle after the pin changes.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;

  localparam int POS_RATE_LO  = 1;
  localparam int POS_MULT_LO  = 5;
  localparam int POS_ENDIAN   = 8;
  localparam int POS_NBW_LO   = 9;
  localparam int POS_TIMER    = 11;
  localparam int POS_L2       = 12;
  localparam int POS_DRV_LO   = 13;
  localparam int POS_SRAM     = 15;
  localparam int POS_CFG_LO   = 16;
  localparam int POS_HALF     = 20;
  localparam int POS_BUS      = 21;
  localparam int MAX_RATE     = 8;

  typedef struct packed {
    logic [3:0] wb_rate;
    logic [2:0] mult_code;
    logic       mult_half;
    logic [1:0] nbw_ctrl;
    logic       timer_int_en;
    logic       l2_en;
    logic       sram_scd;
    logic [6:0] drive_pct;
    logic [1:0] cfg_id;
    logic       bus32;
  } mode_fields_t;

  function automatic logic is_reserved(input int idx);
    return (idx == 0) || (idx == 18) || (idx == 19) || (idx >= 22);
  endfunction

  function automatic logic [6:0] strength_pct(input logic [1:0] code);
    case (code)
      2'b00:   return 7'd67;
      2'b01:   return 7'd50;
      2'b10:   return 7'd100;
      default: return 7'd83;
    endcase
  endfunction

endpackage

// File: rtl/mode_clk_div.sv
module mode_clk_div #(
  parameter int DIV_LOG2 = 8
) (
  input  logic clk,
  input  logic rst,
  output logic mode_clk,
  output logic sample_stb
);
  localparam logic [DIV_LOG2-1:0] HALF_M1 = DIV_LOG2'((1 << (DIV_LOG2 - 1)) - 1);

  logic [DIV_LOG2-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + 1'b1;
  end

  assign mode_clk   = phase_q[DIV_LOG2-1];
  assign sample_stb = !rst && (phase_q == HALF_M1);
endmodule

// File: rtl/mode_shift_capture.sv
module mode_shift_capture #(
  parameter int N_BITS = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_stb,
  input  logic              din,
  output logic [N_BITS-1:0] frame,
  output logic              last_stb
);
  localparam int CW = $clog2(N_BITS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(N_BITS - 1);

  logic [N_BITS-1:0] shreg_q;
  logic [CW-1:0]     count_q;
  logic              full_q;
  logic              take;

  assign take     = sample_stb && !full_q;
  assign last_stb = take && (count_q == LAST_IDX);
  assign frame    = {din, shreg_q[N_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      count_q <= '0;
      full_q  <= 1'b0;
    end else if (take) begin
      shreg_q <= frame;
      count_q <= count_q + 1'b1;
      if (last_stb) full_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import boot_mode_pkg::*;
#(
  parameter int N_BITS = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [N_BITS-1:0] frame,
  input  logic              be_pin,
  output mode_fields_t      fields,
  output logic              done,
  output logic              big_endian,
  output logic              cfg_err
);
  mode_fields_t nxt;
  logic         rsv_any;
  logic         endian_q;

  always_comb begin
    rsv_any = 1'b0;
    for (int i = 0; i < N_BITS; i++) begin
      if (is_reserved(i) && frame[i]) rsv_any = 1'b1;
    end
  end

  always_comb begin
    nxt.wb_rate      = frame[POS_RATE_LO +: 4];
    nxt.mult_code    = frame[POS_MULT_LO +: 3];
    nxt.mult_half    = frame[POS_HALF];
    nxt.nbw_ctrl     = frame[POS_NBW_LO +: 2];
    nxt.timer_int_en = !frame[POS_TIMER];
    nxt.l2_en        = frame[POS_L2];
    nxt.sram_scd     = frame[POS_SRAM];
    nxt.drive_pct    = strength_pct(frame[POS_DRV_LO +: 2]);
    nxt.cfg_id       = frame[POS_CFG_LO +: 2];
    nxt.bus32        = frame[POS_BUS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fields     <= '0;
      done       <= 1'b0;
      endian_q   <= 1'b0;
      big_endian <= 1'b0;
      cfg_err    <= 1'b0;
    end else begin
      if (load) begin
        fields   <= nxt;
        done     <= 1'b1;
        endian_q <= frame[POS_ENDIAN];
        if (rsv_any || (nxt.wb_rate > 4'(MAX_RATE))) cfg_err <= 1'b1;
      end
      big_endian <= (load ? frame[POS_ENDIAN] : endian_q) | be_pin;
    end
  end
endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader
  import boot_mode_pkg::*;
#(
  parameter int N_BITS   = 256,
  parameter int DIV_LOG2 = 8
) (
  input  logic       clk,
  input  logic       pwr_ok,
  input  logic       mode_din,
  input  logic       be_pin,
  output logic       mode_clk,
  output logic       done,
  output logic [3:0] wb_rate,
  output logic [2:0] mult_code,
  output logic       mult_half,
  output logic       big_endian,
  output logic [1:0] nbw_ctrl,
  output logic       timer_int_en,
  output logic       l2_en,
  output logic       sram_scd,
  output logic [6:0] drive_pct,
  output logic [1:0] cfg_id,
  output logic       bus32,
  output logic       cfg_err
);
  logic              rst;
  logic              sample_stb;
  logic              last_stb;
  logic [N_BITS-1:0] frame;
  mode_fields_t      fields;

  assign rst = !pwr_ok;

  mode_clk_div #(.DIV_LOG2(DIV_LOG2)) div_i (
    .clk(clk), .rst(rst), .mode_clk(mode_clk), .sample_stb(sample_stb)
  );

  mode_shift_capture #(.N_BITS(N_BITS)) cap_i (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .din(mode_din),
    .frame(frame), .last_stb(last_stb)
  );

  mode_decode #(.N_BITS(N_BITS)) dec_i (
    .clk(clk), .rst(rst), .load(last_stb), .frame(frame), .be_pin(be_pin),
    .fields(fields), .done(done), .big_endian(big_endian), .cfg_err(cfg_err)
  );

  assign wb_rate      = fields.wb_rate;
  assign mult_code    = fields.mult_code;
  assign mult_half    = fields.mult_half;
  assign nbw_ctrl     = fields.nbw_ctrl;
  assign timer_int_en = fields.timer_int_en;
  assign l2_en        = fields.l2_en;
  assign sram_scd     = fields.sram_scd;
  assign drive_pct    = fields.drive_pct;
  assign cfg_id       = fields.cfg_id;
  assign bus32        = fields.bus32;
endmodule

// File: rtl/boot_mode_loader_chk.sv
module boot_mode_loader_chk (
  input logic       clk,
  input logic       pwr_ok,
  input logic       be_pin,
  input logic       mode_clk,
  input logic       done,
  input logic [3:0] wb_rate,
  input logic [2:0] mult_code,
  input logic [6:0] drive_pct,
  input logic       big_endian,
  input logic       cfg_err
);
  logic seen_q = 1'b0;
  always_ff @(posedge clk) seen_q <= 1'b1;

  // R9: a cycle with power low leaves the block idle
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!seen_q)
    !pwr_ok |=> (!done && !mode_clk && !cfg_err));

  // R3: once done, fields hold
  a_r3_fields_hold: assert property (@(posedge clk) disable iff (!pwr_ok)
    done |=> (done && $stable(wb_rate) && $stable(mult_code) && $stable(drive_pct)));

  // R8: error flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!pwr_ok)
    cfg_err |=> cfg_err);

  // R2: capture completes on a mode clock rising edge
  a_r2_done_on_rise: assert property (@(posedge clk) disable iff (!pwr_ok)
    $rose(done) |-> $rose(mode_clk));

  // R6: strength is one of the four legal values once loaded
  a_r6_drive_legal: assert property (@(posedge clk) disable iff (!pwr_ok)
    done |-> (drive_pct == 7'd50 || drive_pct == 7'd67 ||
              drive_pct == 7'd83 || drive_pct == 7'd100));

  // R7: the strap pin forces big endian one cycle later
  a_r7_endian_pin: assert property (@(posedge clk) disable iff (!pwr_ok)
    ($past(pwr_ok) && $past(be_pin)) |-> big_endian);
endmodule

bind boot_mode_loader boot_mode_loader_chk chk_i (
  .clk(clk), .pwr_ok(pwr_ok), .be_pin(be_pin), .mode_clk(mode_clk),
  .done(done), .wb_rate(wb_rate), .mult_code(mult_code),
  .drive_pct(drive_pct), .big_endian(big_endian), .cfg_err(cfg_err)
);

// File: tb/boot_mode_loader_tb_top.sv
`timescale 1ns/1ps
module boot_mode_loader_tb_top;
  logic clk = 1'b0;
  logic pwr_ok = 1'b0, mode_din = 1'b0, be_pin = 1'b0;
  logic mode_clk, done, mult_half, big_endian, timer_int_en, l2_en, sram_scd, bus32, cfg_err;
  logic [3:0] wb_rate;
  logic [2:0] mult_code;
  logic [1:0] nbw_ctrl, cfg_id;
  logic [6:0] drive_pct;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  boot_mode_loader dut_i (
    .clk(clk), .pwr_ok(pwr_ok), .mode_din(mode_din), .be_pin(be_pin),
    .mode_clk(mode_clk), .done(done), .wb_rate(wb_rate), .mult_code(mult_code),
    .mult_half(mult_half), .big_endian(big_endian), .nbw_ctrl(nbw_ctrl),
    .timer_int_en(timer_int_en), .l2_en(l2_en), .sram_scd(sram_scd),
    .drive_pct(drive_pct), .cfg_id(cfg_id), .bus32(bus32), .cfg_err(cfg_err)
  );

  // behavioural reference
  int         m_phase = 0, m_n = 0;
  bit         m_done = 0, m_err = 0, m_be = 0;
  bit [255:0] m_bits = '0;

  function automatic bit bad_frame(bit [255:0] f);
    bit r = f[0] | f[18] | f[19];
    for (int i = 22; i < 256; i++) r |= f[i];
    return r || (f[4:1] > 4'd8);
  endfunction

  function automatic int pct_of(bit [1:0] c);
    return (c == 2'b00) ? 67 : (c == 2'b01) ? 50 : (c == 2'b10) ? 100 : 83;
  endfunction

  always @(posedge clk) begin
    if (!pwr_ok) begin
      m_phase = 0; m_n = 0; m_done = 0; m_err = 0; m_be = 0; m_bits = '0;
    end else begin
      if (m_phase == 127 && !m_done) begin
        m_bits[m_n] = mode_din;
        m_n++;
        if (m_n == 256) begin
          m_done = 1;
          m_err = bad_frame(m_bits);
        end
      end
      m_be = (m_done & m_bits[8]) | be_pin;
      m_phase = (m_phase + 1) % 256;
    end
  end

  task automatic chk(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R1", "mode_clk", mode_clk, (m_phase >= 128) ? 1 : 0);
    chk("R3", "done", done, m_done);
    chk("R4", "wb_rate", wb_rate, m_done ? m_bits[4:1] : 0);
    chk("R4", "mult_code", mult_code, m_done ? m_bits[7:5] : 0);
    chk("R4", "mult_half", mult_half, m_done ? m_bits[20] : 0);
    chk("R4", "nbw_ctrl", nbw_ctrl, m_done ? m_bits[10:9] : 0);
    chk("R4", "l2_en", l2_en, m_done ? m_bits[12] : 0);
    chk("R4", "sram_scd", sram_scd, m_done ? m_bits[15] : 0);
    chk("R4", "cfg_id", cfg_id, m_done ? m_bits[17:16] : 0);
    chk("R4", "bus32", bus32, m_done ? m_bits[21] : 0);
    chk("R5", "timer_int_en", timer_int_en, m_done ? !m_bits[11] : 0);
    chk("R6", "drive_pct", drive_pct, m_done ? pct_of(m_bits[14:13]) : 0);
    chk("R7", "big_endian", big_endian, m_be);
    chk("R8", "cfg_err", cfg_err, m_err);
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic shift_bits(bit [255:0] s, int count);
    for (int i = 0; i < count; i++) begin
      mode_din = s[i];
      repeat (256) @(negedge clk);
    end
  endtask

  bit [255:0] stream_a, stream_b;

  initial begin
    stream_a = '0;
    stream_a[4:1] = 4'd8; stream_a[7:5] = 3'd5; stream_a[10:9] = 2'b10;
    stream_a[11] = 1; stream_a[12] = 1; stream_a[14:13] = 2'b11;
    stream_a[15] = 1; stream_a[17:16] = 2'b01; stream_a[20] = 1;
    stream_b = '0;
    stream_b[4:1] = 4'd12; stream_b[8] = 1; stream_b[21] = 1; stream_b[200] = 1;

    repeat (4) @(negedge clk);
    chk("R9", "idle done", done, 0);
    chk("R9", "idle mode_clk", mode_clk, 0);

    pwr_ok = 1;
    shift_bits(stream_a, 256);
    chk("R3", "done after A", done, 1);
    chk("R4", "rate 8", wb_rate, 8);
    chk("R4", "mult 5", mult_code, 5);
    chk("R4", "half", mult_half, 1);
    chk("R5", "timer off", timer_int_en, 0);
    chk("R6", "pct 83", drive_pct, 83);
    chk("R8", "rate 8 no err", cfg_err, 0);
    be_pin = 1;
    @(negedge clk); chk("R7", "pin high", big_endian, 1);
    be_pin = 0;
    @(negedge clk); chk("R7", "pin low", big_endian, 0);

    pwr_ok = 0;
    repeat (3) @(negedge clk);
    pwr_ok = 1;
    shift_bits(stream_b, 10);
    pwr_ok = 0;
    repeat (2) @(negedge clk);
    chk("R9", "abort done", done, 0);
    chk("R9", "abort fields", wb_rate, 0);

    pwr_ok = 1;
    shift_bits(stream_b, 256);
    chk("R8", "err set", cfg_err, 1);
    chk("R5", "timer on", timer_int_en, 1);
    chk("R6", "pct 67", drive_pct, 67);
    chk("R4", "bus32", bus32, 1);
    chk("R7", "endian bit", big_endian, 1);
    repeat (300) @(negedge clk);
    chk("R8", "err sticky", cfg_err, 1);
    pwr_ok = 0;
    repeat (2) @(negedge clk);
    chk("R9", "err cleared", cfg_err, 0);
    chk("R9", "done cleared", done, 0);
    finish_run();
  end
endmodule